// File: doc/BRIEF.md
# Two-Dimensional Strided DMA Channel

This block is a single channel of a DMA engine that moves data between memory and a peripheral over a rectangular region. The region is a set of lines. Each line holds a fixed number of words. The start of each line lies a programmable stride beyond the start of the line before it, so the gap words between lines are skipped. Software first sets the line length, the line count, the stride and a control word. It then writes the start word address, and that write launches the channel.

While active, the channel places word read or word write requests on a request/acknowledge memory port. It paces these requests against a peripheral handshake. A peripheral request input says the peripheral can move data. A separate input says that four words can be moved at once. The current word address is always visible, so software can work out how many words remain. When the last word of the last line has been moved, the channel raises its bit in a one-hot completion vector for one cycle and returns to idle. An abort input stops the channel at once.

Top module: `dma2d_chan`

## Requirements
- R1: After reset the channel is idle: `busy`, `memReq` and `doneVec` are 0 and `addrNow` is 0.
- R2: Writing the start address (`regSel` = 0) while idle launches the transfer: `busy` is 1 from the following cycle, and the first word requested is the written address.
- R3: Within a line, each accepted request advances the address by the number of words it moved (1, or 4 for a burst).
- R4: After the last word of a line, the next request addresses the previous line start plus the stride (`regSel` = 3), not the word after the line.
- R5: The number of lines moved is the line-count field (`regSel` = 2) plus one, so 0 moves one line. Each line moves the line-length field (`regSel` = 1) in words, and a length of 0 moves one word.
- R6: Control bit 4 set selects burst mode. In burst mode a request carries `memBurst` = 1 (four words) only if `perBurstOk` is high when the request is raised and at least four words remain in the line. In every other case a request moves one word.
- R7: Control bit 5 selects the direction. A 1 means memory to device, and requests are reads (`memWrite` = 0). A 0 means device to memory, and requests are writes (`memWrite` = 1).
- R8: A request is raised only after `perReq` was high. Once raised, it holds its address and size until `memAck` is seen. A request completes on a cycle where both `memReq` and `memAck` are high.
- R9: The cycle after the final word is accepted, `doneVec` carries a single 1 at the position given by control bits [3:0] and `busy` is 0. On the next cycle `doneVec` is 0 again.
- R10: While busy, register writes have no effect. Neither the transfer parameters nor the current address change.
- R11: An `abort` while busy returns the channel to idle on the next cycle with `memReq` low and no completion pulse.
- R12: `addrNow` gives the live word address of the next word still to move. This includes after an abort.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regSel | input | 3 | Register select: 0 address, 1 line length, 2 line count, 3 stride, 4 control |
| regWdata | input | ADDR_W (16) | Register write data |
| abort | input | 1 | Stop the active transfer |
| perReq | input | 1 | Peripheral can move data |
| perBurstOk | input | 1 | Peripheral can move four words at once |
| memAck | input | 1 | Memory accepts the pending request |
| memReq | output | 1 | Memory request pending |
| memWrite | output | 1 | 1 = memory write, 0 = memory read |
| memBurst | output | 1 | Request moves four words instead of one |
| memAddr | output | ADDR_W (16) | Word address of the request |
| addrNow | output | ADDR_W (16) | Live current word address |
| busy | output | 1 | Transfer active |
| doneVec | output | NUM_CH (16) | One-hot completion pulse |

## Verification
Directed shapes come first. These are a single short line, lines with a gap that force the stride jump, contiguous lines where the stride equals the length, and a zero length. Line lengths that are not multiples of four show how the block mixes bursts and single words. The same shapes run with `perBurstOk` held low, which shows that bursts depend on the peripheral. Random shapes, channel numbers, directions and acknowledge timing then go against a bench address model that predicts every accepted request. Two further runs target specific paths: an abort in mid-line, and register writes poked in while busy. Together these separate the abort path and the register freeze from normal completion.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  typedef enum logic [2:0] {
    SEL_ADDR   = 3'd0,
    SEL_LEN    = 3'd1,
    SEL_LINES  = 3'd2,
    SEL_STRIDE = 3'd3,
    SEL_CTRL   = 3'd4
  } regSel_e;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } chanState_e;

  // Strobes from the control FSM to the address datapath.
  typedef struct packed {
    logic launch;    // load start address into current and line-start
    logic step;      // advance current address by the words just moved
    logic four;      // the move was a four-word burst
    logic nextLine;  // jump to previous line start plus stride
  } dmaStrobe_t;

  localparam int BURST_WORDS = 4;
  localparam int CTRL_BURST_BIT = 4;
  localparam int CTRL_DIR_BIT = 5;

endpackage

// File: rtl/dma2d_datapath.sv
module dma2d_datapath
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W = 8,
  parameter int CH_BITS = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [2:0]         regSel,
  input  logic [ADDR_W-1:0]  regWdata,
  input  logic               busy,
  input  dmaStrobe_t         strobe,
  output logic [ADDR_W-1:0]  curAddr,
  output logic [LEN_W-1:0]   lineLen,
  output logic [LEN_W-1:0]   lineCnt,
  output logic [CH_BITS-1:0] chanId,
  output logic               burstMode,
  output logic               dirToDev
);

  logic [ADDR_W-1:0] strideReg;
  logic [ADDR_W-1:0] lineStart;
  logic [ADDR_W-1:0] nextStart;
  logic [ADDR_W-1:0] stepSize;

  assign nextStart = lineStart + strideReg;
  assign stepSize  = strobe.four ? ADDR_W'(BURST_WORDS) : ADDR_W'(1);

  // Parameter registers: writable only while idle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineLen   <= '0;
      lineCnt   <= '0;
      strideReg <= '0;
      chanId    <= '0;
      burstMode <= 1'b0;
      dirToDev  <= 1'b0;
    end else if (regWr && !busy) begin
      case (regSel)
        SEL_LEN:    lineLen   <= regWdata[LEN_W-1:0];
        SEL_LINES:  lineCnt   <= regWdata[LEN_W-1:0];
        SEL_STRIDE: strideReg <= regWdata;
        SEL_CTRL: begin
          chanId    <= regWdata[CH_BITS-1:0];
          burstMode <= regWdata[CTRL_BURST_BIT];
          dirToDev  <= regWdata[CTRL_DIR_BIT];
        end
        default: ;
      endcase
    end
  end

  // Running address and start of the current line.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      lineStart <= '0;
    end else if (strobe.launch) begin
      curAddr   <= regWdata;
      lineStart <= regWdata;
    end else if (strobe.nextLine) begin
      curAddr   <= nextStart;
      lineStart <= nextStart;
    end else if (strobe.step) begin
      curAddr   <= curAddr + stepSize;
    end
  end

  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy && regWr |=> $stable(lineLen) && $stable(lineCnt) && $stable(strideReg)
                      && $stable(chanId) && $stable(burstMode) && $stable(dirToDev));

  p_line_jump_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.nextLine && !strobe.launch |=> curAddr == lineStart);

endmodule

// File: rtl/dma2d_ctrl.sv
module dma2d_ctrl
  import dma2d_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int NUM_CH = 16,
  parameter int CH_BITS = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [2:0]         regSel,
  input  logic               abort,
  input  logic               perReq,
  input  logic               perBurstOk,
  input  logic               memAck,
  input  logic [LEN_W-1:0]   lineLen,
  input  logic [LEN_W-1:0]   lineCnt,
  input  logic [CH_BITS-1:0] chanId,
  input  logic               burstMode,
  output logic               busy,
  output logic               memReq,
  output logic               memBurst,
  output dmaStrobe_t         strobe,
  output logic [NUM_CH-1:0]  doneVec
);

  localparam int CNT_W = LEN_W + 1;

  chanState_e state;
  logic [CNT_W-1:0] wordCnt;
  logic [LEN_W-1:0] lineIdx;
  logic [CNT_W-1:0] remaining;
  logic [CNT_W-1:0] newCnt;
  logic launch, xfer, lineEnd, lastLine, finish, burstFit;

  assign busy      = (state == ST_ACTIVE);
  assign launch    = !busy && regWr && (regSel == SEL_ADDR);
  assign xfer      = busy && memReq && memAck && !abort;
  assign remaining = {1'b0, lineLen} - wordCnt;
  assign burstFit  = burstMode && perBurstOk && (remaining >= CNT_W'(BURST_WORDS));
  assign newCnt    = wordCnt + (memBurst ? CNT_W'(BURST_WORDS) : CNT_W'(1));
  assign lineEnd   = xfer && (newCnt >= {1'b0, lineLen});
  assign lastLine  = (lineIdx == lineCnt);
  assign finish    = lineEnd && lastLine;

  always_comb begin
    strobe.launch   = launch;
    strobe.four     = memBurst;
    strobe.nextLine = lineEnd && !lastLine;
    strobe.step     = xfer && !(lineEnd && !lastLine);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      wordCnt  <= '0;
      lineIdx  <= '0;
      memReq   <= 1'b0;
      memBurst <= 1'b0;
      doneVec  <= '0;
    end else begin
      doneVec <= '0;
      case (state)
        ST_IDLE: begin
          memReq <= 1'b0;
          if (launch) begin
            state   <= ST_ACTIVE;
            wordCnt <= '0;
            lineIdx <= '0;
          end
        end
        ST_ACTIVE: begin
          if (abort) begin
            state  <= ST_IDLE;
            memReq <= 1'b0;
          end else if (xfer) begin
            memReq <= 1'b0;
            if (finish) begin
              state   <= ST_IDLE;
              doneVec <= NUM_CH'(1) << chanId;
            end else if (lineEnd) begin
              wordCnt <= '0;
              lineIdx <= lineIdx + LEN_W'(1);
            end else begin
              wordCnt <= newCnt;
            end
          end else if (!memReq && perReq) begin
            memReq   <= 1'b1;
            memBurst <= burstFit;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck && !abort |=> memReq && $stable(memBurst));

  p_req_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) |-> $past(perReq));

  p_burst_room_r6: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memBurst |-> burstMode && (remaining >= CNT_W'(BURST_WORDS)));

  p_done_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(doneVec));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (|doneVec) |-> !busy);

  p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    busy && abort |=> !busy && !memReq && (doneVec == '0));

endmodule

// File: rtl/dma2d_chan.sv
module dma2d_chan
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W = 8,
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [2:0]        regSel,
  input  logic [ADDR_W-1:0] regWdata,
  input  logic              abort,
  input  logic              perReq,
  input  logic              perBurstOk,
  input  logic              memAck,
  output logic              memReq,
  output logic              memWrite,
  output logic              memBurst,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] addrNow,
  output logic              busy,
  output logic [NUM_CH-1:0] doneVec
);

  // Channel number sits below the burst bit of the control word.
  localparam int CH_BITS = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  dmaStrobe_t strobe;
  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0] lineLen, lineCnt;
  logic [CH_BITS-1:0] chanId;
  logic burstMode, dirToDev;

  dma2d_ctrl #(.LEN_W(LEN_W), .NUM_CH(NUM_CH), .CH_BITS(CH_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .abort(abort),
    .perReq(perReq), .perBurstOk(perBurstOk), .memAck(memAck),
    .lineLen(lineLen), .lineCnt(lineCnt), .chanId(chanId), .burstMode(burstMode),
    .busy(busy), .memReq(memReq), .memBurst(memBurst), .strobe(strobe),
    .doneVec(doneVec)
  );

  dma2d_datapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CH_BITS(CH_BITS)) uPath (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .regWdata(regWdata),
    .busy(busy), .strobe(strobe), .curAddr(curAddr), .lineLen(lineLen),
    .lineCnt(lineCnt), .chanId(chanId), .burstMode(burstMode), .dirToDev(dirToDev)
  );

  assign memAddr  = curAddr;
  assign addrNow  = curAddr;
  assign memWrite = !dirToDev;

  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck && !abort |=> $stable(memAddr));

endmodule

// File: tb/tb_dma2d_chan.sv
module tb_dma2d_chan;
  import dma2d_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0;
  logic [2:0] regSel = '0;
  logic [15:0] regWdata = '0;
  logic abort = 1'b0, perReq = 1'b0, perBurstOk = 1'b0, memAck = 1'b0;
  logic memReq, memWrite, memBurst, busy;
  logic [15:0] memAddr, addrNow, doneVec;

  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  dma2d_chan dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .regWdata(regWdata),
    .abort(abort), .perReq(perReq), .perBurstOk(perBurstOk), .memAck(memAck),
    .memReq(memReq), .memWrite(memWrite), .memBurst(memBurst), .memAddr(memAddr),
    .addrNow(addrNow), .busy(busy), .doneVec(doneVec)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit expBurst(input logic [5:0] ctrl, input bit okC,
                                  input int effLen, input int word);
    return ctrl[4] && okC && ((effLen - word) >= 4);
  endfunction

  task automatic writeReg(input regSel_e sel, input logic [15:0] val);
    @(negedge clk);
    regWr = 1'b1;
    regSel = sel;
    regWdata = val;
  endtask

  task automatic runXfer(input logic [15:0] start, input int len, input int lines,
                         input int stride, input logic [5:0] ctrl, input bit okC,
                         input int abortAt, input bit poke);
    logic [15:0] mAddr, mStart;
    int mWord, mLine, effLen, cyc, words;
    bit fin, prevReq, prevPer, poked, b;
    writeReg(SEL_LEN, 16'(len));
    writeReg(SEL_LINES, 16'(lines));
    writeReg(SEL_STRIDE, 16'(stride));
    writeReg(SEL_CTRL, {10'd0, ctrl});
    writeReg(SEL_ADDR, start);
    perBurstOk = okC;
    @(negedge clk);
    regWr = 1'b0;
    check(busy === 1'b1 && memReq === 1'b0, "R2 launch", {busy, memReq}, 2'b10);
    mAddr = start; mStart = start; mWord = 0; mLine = 0;
    effLen = (len == 0) ? 1 : len;
    cyc = 0; words = 0; fin = 0; prevReq = 0; prevPer = 0; poked = 0;
    while (!fin && cyc < 3000) begin
      if (memReq && !prevReq)
        check(prevPer, "R8 request without perReq", prevPer, 1);
      if (abortAt >= 0 && words >= abortAt) begin
        abort = 1'b1; memAck = 1'b0;
        @(negedge clk);
        abort = 1'b0;
        check(busy === 1'b0 && memReq === 1'b0, "R11 abort idle", {busy, memReq}, 0);
        check(doneVec === 16'h0, "R11 no done on abort", doneVec, 0);
        check(addrNow === mAddr, "R12 addrNow after abort", addrNow, mAddr);
        return;
      end
      if (poke && words == 1 && !poked) begin
        poked = 1;
        memAck = 1'b0;
        regWr = 1'b1; regSel = SEL_LINES; regWdata = 16'(lines + 3);
        @(negedge clk);
        regSel = SEL_ADDR; regWdata = 16'hBEEF;
        @(negedge clk);
        regWr = 1'b0;
        check(addrNow === mAddr && busy === 1'b1, "R10 write while busy", addrNow, mAddr);
        prevReq = 1'b1; prevPer = perReq;
        continue;
      end
      memAck = (($urandom % 100) < 60);
      perReq = (($urandom % 100) < 70);
      if (memReq && memAck) begin
        b = expBurst(ctrl, okC, effLen, mWord);
        check(memAddr === mAddr, "R3 R4 request address", memAddr, mAddr);
        check(memBurst === b, "R6 burst choice", memBurst, b);
        check(memWrite === !ctrl[5], "R7 direction", memWrite, !ctrl[5]);
        mWord += b ? 4 : 1;
        words += b ? 4 : 1;
        if (mWord >= effLen) begin
          if (mLine == lines) begin
            fin = 1;
            mAddr = mAddr + (b ? 16'd4 : 16'd1);
          end else begin
            mLine++;
            mStart = mStart + 16'(stride);
            mAddr = mStart;
            mWord = 0;
          end
        end else begin
          mAddr = mAddr + (b ? 16'd4 : 16'd1);
        end
      end
      prevReq = memReq;
      prevPer = perReq;
      @(negedge clk);
      cyc++;
    end
    memAck = 1'b0; perReq = 1'b0;
    if (!fin) begin
      check(1'b0, "R5 transfer did not complete", mLine, lines);
    end else begin
      check(doneVec === (16'd1 << ctrl[3:0]) && busy === 1'b0, "R9 done pulse",
            {busy, doneVec}, 16'd1 << ctrl[3:0]);
      check(addrNow === mAddr, "R12 addrNow at end", addrNow, mAddr);
      @(negedge clk);
      check(doneVec === 16'h0, "R9 done one cycle", doneVec, 0);
    end
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    check(1'b0, "watchdog expired", wd, 0);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && memReq === 1'b0 && doneVec === 16'h0 && addrNow === 16'h0,
          "R1 reset state", {busy, memReq, addrNow}, 0);
    // Directed shapes
    runXfer(16'h0100, 3, 0, 3, 6'b10_0010, 1'b1, -1, 1'b0); // R5: one line
    runXfer(16'h0200, 5, 2, 8, 6'b01_0101, 1'b1, -1, 1'b0); // R4 R6 gap + burst+single
    runXfer(16'h0300, 8, 1, 10, 6'b01_0011, 1'b0, -1, 1'b0); // R6 no peripheral burst
    runXfer(16'h0400, 4, 3, 4, 6'b11_1111, 1'b1, -1, 1'b0); // R3 contiguous bursts
    runXfer(16'h0500, 0, 2, 6, 6'b00_0000, 1'b1, -1, 1'b0); // R5 zero length
    runXfer(16'hFFFC, 6, 1, 7, 6'b01_1001, 1'b1, -1, 1'b0); // address wrap
    runXfer(16'h0600, 9, 2, 12, 6'b01_0100, 1'b1, 6, 1'b0); // R11 abort mid-line
    runXfer(16'h0700, 3, 1, 5, 6'b10_0111, 1'b0, -1, 1'b1); // R10 poke while busy
    // Random shapes
    for (int i = 0; i < 12; i++) begin
      int len, lines;
      len = 1 + ($urandom % 12);
      lines = $urandom % 4;
      runXfer(16'($urandom), len, lines, len + ($urandom % 6), 6'($urandom),
              1'($urandom), -1, 1'b0);
    end
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule